// File: doc/BRIEF.md
# Triple Match Timer

This block holds three independent 32-bit timers behind one word-addressed register bus. Each timer steps its counter once per enabled tick, either up or down. The tick comes from every bus clock or from an external tick-enable pin. When the counter runs off its end, it takes its load value again. Each timer also carries two match values. A match is recorded when the counter equals a match value on a tick.

Every timer reports three events: first match, second match and overflow. These events are gathered in one shared sticky state register, and software clears it by writing ones. A shared mask register decides which recorded events reach the single interrupt pin.

The bus has no handshake. A write takes effect at the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`, and bits 1:0 of the address are ignored.

Top module: `triple_match_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Timer t (t = 0, 1, 2) has four registers at byte address 16·t: counter at +0, load at +4, first match at +8 and second match at +12, all read back as written. The control register sits at 0x30. It holds enable at bit 3t, clock select at bit 3t+1, overflow enable at bit 3t+2 and count direction at bit 9+t (1 = up), and bits 31:12 read 0. The state register is at 0x34 and the mask register at 0x38. Both use bits 8:0, and the upper bits read 0.
- R3: With enable clear, the counter holds its value. With clock select 0, an enabled counter steps on every clock. With clock select 1, it steps only on clock edges where `tick_ext` is high.
- R4: Counting down, a tick decrements the counter, and a tick at 0 loads the load value instead.
- R5: Counting up, a tick increments the counter, and a tick at 0xFFFFFFFF loads the load value instead.
- R6: A reload sets the timer's overflow state bit (3t+2) only when its overflow enable bit is set. The reload itself happens either way.
- R7: A tick on which the counter, before stepping, equals the first match value sets state bit 3t. A tick on which it equals the second match value sets state bit 3t+1.
- R8: State bits stay set until a write to 0x34 with a 1 in that bit position clears them. An event arriving on the same edge as that clear leaves the bit set.
- R9: `irq` is high exactly when some state bit is set whose mask bit is 0. A mask bit of 1 suppresses that event on the pin.
- R10: A software write to a counter on the same edge as one of its ticks wins. The tick is dropped, so there is no step and no events from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ext | input | 1 | External tick enable, used by timers whose clock select is 1 |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | OR of unmasked state bits |

## Verification
Two collisions are driven on purpose. In the first, a write-one-to-clear lands on the exact edge where a running timer records a match. The state bit is then read back and must still be set; a second, lone clear must then remove it. In the second, a counter write lands on an edge where that counter is ticking, and its pre-write value equals the first match value. The counter must then show the written value minus only the later ticks, and the first-match bit must stay clear. Randomised runs compare counter and state against a bench model of stepping, reload and matching.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // word index of a timer's registers inside its 16-byte block
  localparam logic [1:0] REG_CNT  = 2'd0;
  localparam logic [1:0] REG_LOAD = 2'd1;
  localparam logic [1:0] REG_M1   = 2'd2;
  localparam logic [1:0] REG_M2   = 2'd3;

  // word index of the shared registers inside the block after the timers
  localparam logic [1:0] SH_CTRL  = 2'd0;
  localparam logic [1:0] SH_STATE = 2'd1;
  localparam logic [1:0] SH_MASK  = 2'd2;

  // events and control bits per timer, and their order inside a timer's field
  localparam int EVT_PER_TMR = 3;
  localparam int EV_M1  = 0;
  localparam int EV_M2  = 1;
  localparam int EV_OVF = 2;
  localparam int CT_EN  = 0;
  localparam int CT_SEL = 1;
  localparam int CT_OVF = 2;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_ext,
  input  logic                   en,
  input  logic                   clk_sel,
  input  logic                   ovf_en,
  input  logic                   count_up,
  input  logic [3:0]             reg_we,
  input  logic [CNT_W-1:0]       wdata,
  output logic [CNT_W-1:0]       cnt_q,
  output logic [CNT_W-1:0]       load_q,
  output logic [CNT_W-1:0]       m1_q,
  output logic [CNT_W-1:0]       m2_q,
  output logic [EVT_PER_TMR-1:0] evt
);

  logic             tick;
  logic             step_ok;
  logic             wrap;
  logic [CNT_W-1:0] cnt_next;

  assign tick     = en && (clk_sel ? tick_ext : 1'b1);
  assign step_ok  = tick && !reg_we[REG_CNT];
  assign wrap     = count_up ? (&cnt_q) : (cnt_q == '0);
  assign cnt_next = count_up ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);

  always_comb begin
    evt         = '0;
    evt[EV_M1]  = step_ok && (cnt_q == m1_q);
    evt[EV_M2]  = step_ok && (cnt_q == m2_q);
    evt[EV_OVF] = step_ok && wrap && ovf_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
      m1_q   <= '0;
      m2_q   <= '0;
    end else begin
      if (reg_we[REG_LOAD]) load_q <= wdata;
      if (reg_we[REG_M1])   m1_q   <= wdata;
      if (reg_we[REG_M2])   m2_q   <= wdata;
      if (reg_we[REG_CNT])  cnt_q  <= wdata;
      else if (tick)        cnt_q  <= wrap ? load_q : cnt_next;
    end
  end

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !reg_we[REG_CNT]) |=> $stable(cnt_q));

  // R10
  cnt_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we[REG_CNT] |=> (cnt_q == $past(wdata)));

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !count_up && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1))));

  // R5
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && count_up && !(&cnt_q)) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && (count_up ? (&cnt_q) : (cnt_q == '0))) |=> (cnt_q == $past(load_q)));

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int NEVT = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt,
  input  logic            clr_we,
  input  logic            mask_we,
  input  logic [NEVT-1:0] wdata,
  output logic [NEVT-1:0] state_q,
  output logic [NEVT-1:0] mask_q,
  output logic            irq
);

  logic [NEVT-1:0] clr_bits;

  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      mask_q  <= '0;
    end else begin
      state_q <= (state_q & ~clr_bits) | evt;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign irq = |(state_q & ~mask_q);

  // R8
  state_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((state_q & $past(state_q & ~clr_bits)) == $past(state_q & ~clr_bits)));

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((state_q & $past(evt)) == $past(evt)));

  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((state_q & $past(clr_bits & ~evt)) == '0));

endmodule

// File: rtl/triple_match_timer.sv
module triple_match_timer
  import tmr_pkg::*;
#(
  parameter int N_TMR  = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ext,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);

  localparam int SEL_W    = ADDR_W - 4;
  localparam int NEVT     = EVT_PER_TMR * N_TMR;
  localparam int DIR_BASE = EVT_PER_TMR * N_TMR;
  localparam int CTRL_W   = DIR_BASE + N_TMR;

  logic [SEL_W-1:0]  blk;
  logic [1:0]        word;
  logic              ctl_hit;
  logic [CTRL_W-1:0] ctrl_q;
  logic [NEVT-1:0]   evt_all;
  logic [NEVT-1:0]   state_q;
  logic [NEVT-1:0]   mask_q;
  logic [CNT_W-1:0]  cnt_a  [N_TMR];
  logic [CNT_W-1:0]  load_a [N_TMR];
  logic [CNT_W-1:0]  m1_a   [N_TMR];
  logic [CNT_W-1:0]  m2_a   [N_TMR];
  logic              unused_bits;

  assign blk         = bus_addr[ADDR_W-1:4];
  assign word        = bus_addr[3:2];
  assign ctl_hit     = (blk == SEL_W'(N_TMR));
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[CNT_W-1:CTRL_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (bus_we && ctl_hit && word == SH_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    logic [3:0] we_v;
    assign we_v = (bus_we && blk == SEL_W'(i)) ? (4'b0001 << word) : 4'b0000;

    tmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_ext (tick_ext),
      .en       (ctrl_q[EVT_PER_TMR*i + CT_EN]),
      .clk_sel  (ctrl_q[EVT_PER_TMR*i + CT_SEL]),
      .ovf_en   (ctrl_q[EVT_PER_TMR*i + CT_OVF]),
      .count_up (ctrl_q[DIR_BASE + i]),
      .reg_we   (we_v),
      .wdata    (bus_wdata),
      .cnt_q    (cnt_a[i]),
      .load_q   (load_a[i]),
      .m1_q     (m1_a[i]),
      .m2_q     (m2_a[i]),
      .evt      (evt_all[EVT_PER_TMR*i +: EVT_PER_TMR])
    );
  end

  tmr_irq_ctrl #(.NEVT(NEVT)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_all),
    .clr_we  (bus_we && ctl_hit && word == SH_STATE),
    .mask_we (bus_we && ctl_hit && word == SH_MASK),
    .wdata   (bus_wdata[NEVT-1:0]),
    .state_q (state_q),
    .mask_q  (mask_q),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (blk == SEL_W'(i)) begin
        case (word)
          REG_CNT:  bus_rdata = cnt_a[i];
          REG_LOAD: bus_rdata = load_a[i];
          REG_M1:   bus_rdata = m1_a[i];
          default:  bus_rdata = m2_a[i];
        endcase
      end
    end
    if (ctl_hit) begin
      case (word)
        SH_CTRL:  bus_rdata = CNT_W'(ctrl_q);
        SH_STATE: bus_rdata = CNT_W'(state_q);
        SH_MASK:  bus_rdata = CNT_W'(mask_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && ctl_hit && word == SH_MASK && bus_wdata[NEVT-1:0] == {NEVT{1'b1}}) |=> !irq);

endmodule

// File: tb/triple_match_timer_test.sv
module triple_match_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_ext = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;

  always #2 clk = ~clk;

  triple_match_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_ext(tick_ext), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(input int ch, input bit en, input bit sel, input bit ovf, input bit up);
    logic [31:0] w = '0;
    w[3*ch] = en; w[3*ch+1] = sel; w[3*ch+2] = ovf; w[9+ch] = up;
    return w;
  endfunction

  task automatic model(input logic [31:0] start, input logic [31:0] ld, input logic [31:0] m1,
                       input logic [31:0] m2, input bit up, input bit ovfen, input int k,
                       output logic [31:0] c, output logic [2:0] f);
    c = start; f = '0;
    for (int s = 0; s < k; s++) begin
      if (c == m1) f[0] = 1'b1;
      if (c == m2) f[1] = 1'b1;
      if (up ? (c == 32'hFFFF_FFFF) : (c == 32'h0)) begin
        c = ld;
        if (ovfen) f[2] = 1'b1;
      end else c = up ? c + 1 : c - 1;
    end
  endtask

  task automatic setup(input int ch, input logic [31:0] c0, input logic [31:0] ld,
                       input logic [31:0] m1, input logic [31:0] m2);
    wr(8'h34, 32'h1FF);
    wr(8'(16*ch + 0), c0);
    wr(8'(16*ch + 4), ld);
    wr(8'(16*ch + 8), m1);
    wr(8'(16*ch + 12), m2);
  endtask

  initial begin
    #400000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, ec, mask;
    logic [2:0]  ef;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 15; a++) begin
      rd(8'(4*a), v);
      check("R1 reset read", v, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R2: register readback with timers disabled
    for (int ch = 0; ch < 3; ch++) begin
      for (int r = 0; r < 4; r++) begin
        logic [31:0] d = $urandom;
        wr(8'(16*ch + 4*r), d);
        rd(8'(16*ch + 4*r), v);
        check("R2 timer reg readback", v, d);
      end
    end
    wr(8'h30, 32'hFFFF_FE00);
    rd(8'h30, v);
    check("R2 control width", v, 32'h0000_0E00);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, v);
    check("R2 mask width", v, 32'h0000_01FF);
    wr(8'h30, 32'h0);
    wr(8'h38, 32'h0);

    // R3: external tick select, then hold when disabled
    begin
      int ones = 0;
      setup(1, 32'd1000, 32'd0, 32'hAAAA_0000, 32'hAAAA_0001);
      wr(8'h30, ctl(1, 1, 1, 0, 0));
      for (int s = 0; s < 20; s++) begin
        bit b = 1'($urandom_range(0, 1));
        @(negedge clk); tick_ext = b; ones += int'(b);
        @(posedge clk);
      end
      @(negedge clk); tick_ext = 1'b0;
      wr(8'h30, ctl(1, 0, 1, 0, 0));
      rd(8'h10, v);
      check("R3 external tick count", v, 32'(1000 - ones));
      repeat (10) @(posedge clk);
      rd(8'h10, ec);
      check("R3 disabled hold", ec, v);
    end

    // R6: reload without overflow enable leaves the bit clear
    setup(0, 32'd2, 32'd77, 32'hAAAA_AAAA, 32'hAAAA_AAAA);
    wr(8'h30, ctl(0, 1, 0, 0, 0));
    repeat (4) @(posedge clk);
    wr(8'h30, ctl(0, 0, 0, 0, 0));
    rd(8'h00, v);
    check("R6 reload without ovf enable counter", v, 32'd75);
    rd(8'h34, v);
    check("R6 ovf bit stays clear", v, 32'h0);

    // R5/R6/R9: upward wrap with overflow enable, masked and unmasked
    wr(8'h38, 32'h100);
    setup(2, 32'hFFFF_FFFE, 32'd10, 32'h5555_5555, 32'h5555_5555);
    wr(8'h30, ctl(2, 1, 0, 1, 1));
    repeat (3) @(posedge clk);
    wr(8'h30, ctl(2, 0, 0, 1, 1));
    rd(8'h20, v);
    check("R5 up wrap reload counter", v, 32'd12);
    rd(8'h34, v);
    check("R6 ovf bit of timer 2", v, 32'h100);
    check("R9 masked event keeps irq low", {31'b0, irq}, 32'h0);
    wr(8'h38, 32'h0);
    rd(8'h34, v);
    check("R9 unmasked event raises irq", {31'b0, irq}, 32'h1);

    // R8: clear lands on the same edge as a first-match event
    setup(0, 32'd5, 32'd100, 32'd3, 32'hDEAD);
    wr(8'h30, ctl(0, 1, 0, 0, 0));
    repeat (2) @(posedge clk);
    wr(8'h34, 32'h1FF);
    wr(8'h30, ctl(0, 0, 0, 0, 0));
    rd(8'h34, v);
    check("R8 set beats same-edge clear", v, 32'h1);
    wr(8'h34, 32'h1);
    rd(8'h34, v);
    check("R8 lone clear", v, 32'h0);
    check("R9 irq low after clear", {31'b0, irq}, 32'h0);

    // R10: counter write on a ticking edge drops that tick
    setup(1, 32'd50, 32'd0, 32'd50, 32'd7);
    wr(8'h30, ctl(1, 1, 0, 0, 0));
    wr(8'h10, 32'd7);
    wr(8'h30, ctl(1, 0, 0, 0, 0));
    rd(8'h10, v);
    check("R10 write wins over tick", v, 32'd6);
    rd(8'h34, v);
    check("R10 dropped tick makes no match", v, 32'h10);

    // R4/R5/R7/R9: randomised runs against the bench model
    for (int it = 0; it < 40; it++) begin
      int ch = $urandom_range(0, 2);
      bit up = 1'($urandom_range(0, 1));
      bit ovf = 1'($urandom_range(0, 1));
      int k = $urandom_range(1, 40);
      logic [31:0] c0, ld, m1, m2;
      c0 = up ? 32'hFFFF_FFFF - $urandom_range(0, 30) : 32'($urandom_range(0, 30));
      ld = up ? 32'hFFFF_FFC0 + $urandom_range(0, 63) : 32'($urandom_range(0, 63));
      m1 = up ? c0 + $urandom_range(0, k) : c0 - $urandom_range(0, k);
      m2 = ($urandom_range(0, 3) == 0) ? $urandom : (up ? ld + $urandom_range(0, 8) : ld - $urandom_range(0, 8));
      mask = 32'($urandom_range(0, 511));
      wr(8'h38, mask);
      setup(ch, c0, ld, m1, m2);
      wr(8'h30, ctl(ch, 1, 0, ovf, up));
      repeat (k - 1) @(posedge clk);
      wr(8'h30, ctl(ch, 0, 0, ovf, up));
      model(c0, ld, m1, m2, up, ovf, k, ec, ef);
      rd(8'(16*ch), v);
      check(up ? "R5 random up count" : "R4 random down count", v, ec);
      rd(8'h34, v);
      check("R7 random event state", v, 32'(ef) << (3*ch));
      check("R9 random irq", {31'b0, irq}, {31'b0, |((32'(ef) << (3*ch)) & ~mask)});
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule